// File: doc/BRIEF.md
# Broadcast Decoder Control Port (I2C Slave)

This block is the serial control port of a broadcast data decoder. An external controller reaches it over a two-wire I2C bus. A single-byte write sets an 8-bit mode register, and the decoder's other logic reads its operating mode from the fields of that register. A read transaction returns the contents of a 16-byte acquisition buffer in sequence. The block drives a byte index that selects the buffer byte, and the buffer answers with that byte on a combinational input.

The slave answers one of two address pairs. A select pin chooses the pair. While the slave is addressed, it raises a busy flag, and the acquisition side uses that flag to hold back updates to the buffer so that a read never sees a half-written record. A one-cycle pulse marks the not-acknowledge that ends a read, which lets a data-valid indicator be cleared at that point.

Both bus lines are brought into the system clock domain through two-flop synchronisers, and edges and bus conditions are detected there. The system clock must run at least ten times faster than SCL. The SDA line is open-drain: the output `sda_oe_o` pulls the line low when it is high.

Top module: `bdec_i2c_slave`

## Requirements
- R1: After reset the mode register reads 0x00, the busy flag is low, SDA is released and the byte index is 0.
- R2: With `addr_sel_i` low the slave acknowledges the address bytes 0x20 (write) and 0x21 (read). With it high, it acknowledges 0x22 (write) and 0x23 (read). It acknowledges by pulling SDA low during the ninth clock.
- R3: The slave does not acknowledge any other address byte. It then ignores all traffic until the next START: later bytes get no acknowledge and the mode register does not change.
- R4: In a write, the first byte after the address is acknowledged and loaded into the mode register. A second data byte in the same transaction is not acknowledged and does not change the register.
- R5: The mode register drives the following fields. Bit 0 is the format select, bit 1 is PDC mode, bit 2 is the header select and bit 3 is the header order. Bits 7..4 are the test bits.
- R6: A read returns buffer bytes starting at index 0, each with bit 7 first. `rd_idx_o` gives the index of the byte being sent.
- R7: The index advances by one only when the master acknowledges a byte. After index 15 it wraps to 0.
- R8: A master not-acknowledge ends the read. SDA stays released, `nack_evt_o` pulses for exactly one cycle, busy drops, and further clocks before a START get no response.
- R9: Every START, including a repeated START, resets the byte index to 0.
- R10: Busy rises when an address matches. It falls on STOP, on a START, or on the not-acknowledge that ends a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| addr_sel_i | input | 1 | Selects the address pair |
| rd_byte_i | input | 8 | Buffer byte at `rd_idx_o` |
| rd_idx_o | output | 4 | Buffer byte index |
| busy_o | output | 1 | Slave addressed; hold buffer updates |
| nack_evt_o | output | 1 | One-cycle pulse on a read-ending NACK |
| ctrl_o | output | 8 | Whole mode register |
| fmt_sel_o | output | 1 | Mode bit 0 |
| pdc_mode_o | output | 1 | Mode bit 1 |
| hdr_sel_o | output | 1 | Mode bit 2 |
| hdr_order_o | output | 1 | Mode bit 3 |
| test_bits_o | output | 4 | Mode bits 7..4 |

## Verification
Two events can land in the same short window: the not-acknowledge that releases busy and pulses the event, and a repeated START that resets the byte index and clears busy again. The bench ends a three-byte read with a not-acknowledge and issues a repeated START straight after it, with no STOP. It then checks three things: exactly one NACK pulse, an index of 0, and that the next read begins again at buffer byte 0. A sweep over all 256 address byte values, with the select pin tied to address bit 1, judges the acknowledge decision against a computed match.

// File: rtl/bdec_i2c_pkg.sv
package bdec_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;

  // mode register field positions
  localparam int FLD_FMT   = 0;
  localparam int FLD_PDC   = 1;
  localparam int FLD_HDR   = 2;
  localparam int FLD_ORDER = 3;
  localparam int TEST_LSB  = 4;

endpackage

// File: rtl/bdec_i2c_sync.sv
module bdec_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync_o,
  output logic prev_o
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], din};

  // idle bus level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/bdec_i2c_cond.sv
module bdec_i2c_cond (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_held_hi;

  always_comb begin
    scl_held_hi = scl_s & scl_q;
    start_o     = scl_held_hi & sda_q & ~sda_s;
    stop_o      = scl_held_hi & ~sda_q & sda_s;
    rise_o      = scl_s & ~scl_q;
    fall_o      = ~scl_s & scl_q;
  end

endmodule

// File: rtl/bdec_i2c_engine.sv
module bdec_i2c_engine
  import bdec_i2c_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         IDX_W    = 4,
  parameter logic [6:0] DEV_BASE = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              sda_oe_o,
  output logic              nack_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  bus_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rnw_q, rnw_d;
  logic              acked_q, acked_d;
  logic              busy_q, busy_d;
  logic              oe_q, oe_d;
  logic              nack_q, nack_d;
  logic [6:0]        my_addr;

  assign my_addr = {DEV_BASE[6:1], addr_sel};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ctrl_d  = ctrl_q;
    idx_d   = idx_q;
    rnw_d   = rnw_q;
    acked_d = acked_q;
    busy_d  = busy_q;
    oe_d    = oe_q;
    nack_d  = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
      busy_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      idx_d   = '0;
      busy_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            rx_d  = {rx_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (state_q == ST_WDATA) begin
              ctrl_d  = rx_q;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end else if (rx_q[7:1] == my_addr) begin
              oe_d    = 1'b1;
              busy_d  = 1'b1;
              rnw_d   = rx_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rnw_q) begin
              tx_d    = rd_byte;
              oe_d    = ~rd_byte[DATA_W-1];
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_IDLE;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d    = 1'b0;
              acked_d = 1'b0;
              state_d = ST_RACK;
            end else begin
              tx_d  = {tx_q[DATA_W-2:0], 1'b0};
              oe_d  = ~tx_q[DATA_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              idx_d   = idx_q + 1'b1;
              acked_d = 1'b1;
            end else begin
              nack_d  = 1'b1;
              busy_d  = 1'b0;
              state_d = ST_IDLE;
            end
          end else if (scl_fall && acked_q) begin
            tx_d    = rd_byte;
            oe_d    = ~rd_byte[DATA_W-1];
            cnt_d   = '0;
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ctrl_q  <= '0;
      idx_q   <= '0;
      rnw_q   <= 1'b0;
      acked_q <= 1'b0;
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ctrl_q  <= ctrl_d;
      idx_q   <= idx_d;
      rnw_q   <= rnw_d;
      acked_q <= acked_d;
      busy_q  <= busy_d;
      oe_q    <= oe_d;
      nack_q  <= nack_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign idx_o    = idx_q;
  assign busy_o   = busy_q;
  assign sda_oe_o = oe_q;
  assign nack_o   = nack_q;

  a_r2_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> busy_q);

  a_r4_ctrl_only_when_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(busy_q));

  a_r7_index_moves_when_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> ($past(busy_q) || $past(start)));

  a_r8_nack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nack_q |=> !nack_q);

  a_r9_start_clears_index: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (idx_q == '0));

  a_r10_busy_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(stop || start || (state_q == ST_RACK && scl_rise && sda_s)));

endmodule

// File: rtl/bdec_i2c_slave.sv
module bdec_i2c_slave
  import bdec_i2c_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         BUF_DEPTH   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'h10,
  localparam int        IDX_W       = $clog2(BUF_DEPTH),
  localparam int        TEST_W      = DATA_W - TEST_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              busy_o,
  output logic              nack_evt_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              fmt_sel_o,
  output logic              pdc_mode_o,
  output logic              hdr_sel_o,
  output logic              hdr_order_o,
  output logic [TEST_W-1:0] test_bits_o
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw_in;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_q;
  logic             start, stop, scl_rise, scl_fall;
  logic [DATA_W-1:0] ctrl;

  // bit 0 carries SCL, bit 1 carries SDA
  assign raw_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    bdec_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (raw_in[g]),
      .sync_o (line_s[g]),
      .prev_o (line_q[g])
    );
  end

  bdec_i2c_cond u_cond (
    .scl_s   (line_s[0]),
    .scl_q   (line_q[0]),
    .sda_s   (line_s[1]),
    .sda_q   (line_q[1]),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  bdec_i2c_engine #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .DEV_BASE (DEV_BASE)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stop     (stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (line_s[1]),
    .addr_sel (addr_sel_i),
    .rd_byte  (rd_byte_i),
    .ctrl_o   (ctrl),
    .idx_o    (rd_idx_o),
    .busy_o   (busy_o),
    .sda_oe_o (sda_oe_o),
    .nack_o   (nack_evt_o)
  );

  assign ctrl_o      = ctrl;
  assign fmt_sel_o   = ctrl[FLD_FMT];
  assign pdc_mode_o  = ctrl[FLD_PDC];
  assign hdr_sel_o   = ctrl[FLD_HDR];
  assign hdr_order_o = ctrl[FLD_ORDER];
  assign test_bits_o = ctrl[DATA_W-1:TEST_LSB];

endmodule

// File: tb/test_bdec_i2c_slave.sv
`timescale 1ns/1ps
module test_bdec_i2c_slave;

  localparam int Q     = 4;
  localparam int LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       addr_sel = 1'b0;
  logic [7:0] rd_byte;
  logic [3:0] rd_idx;
  logic       sda_oe, busy, nack_evt;
  logic [7:0] ctrl;
  logic       fmt_sel, pdc_mode, hdr_sel, hdr_order;
  logic [3:0] test_bits;
  wire        sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nack_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] buf_val(input int k);
    return 8'((k % 16) * 29 + 7);
  endfunction

  assign rd_byte = buf_val(int'(rd_idx));

  bdec_i2c_slave i_bdec_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .rd_byte_i(rd_byte), .rd_idx_o(rd_idx), .busy_o(busy),
    .nack_evt_o(nack_evt), .ctrl_o(ctrl), .fmt_sel_o(fmt_sel), .pdc_mode_o(pdc_mode),
    .hdr_sel_o(hdr_sel), .hdr_order_o(hdr_order), .test_bits_o(test_bits)
  );

  always @(posedge clk) if (rst_n && nack_evt) nack_cnt <= nack_cnt + 1;

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  task automatic chk_mode(input string tag, input logic [7:0] v);
    chk({tag, " ctrl"}, int'(ctrl), int'(v));
    chk({tag, " fields"}, int'({test_bits, hdr_order, hdr_sel, pdc_mode, fmt_sel}), int'(v));
  endtask

  initial begin
    logic       ack;
    logic [7:0] d;
    logic [7:0] exp_ctrl;
    int         n0;

    wq(5);
    rst_n = 1'b1;
    wq(3);
    // R1 reset state
    chk("R1 ctrl", int'(ctrl), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 idx", int'(rd_idx), 0);
    exp_ctrl = 8'h00;

    // R2/R3/R5 sweep of every address byte, select tied to address bit 1
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a;
      logic       match;
      a = 8'(i);
      addr_sel = a[1];
      match = (a[7:2] == 6'b001000);
      bus_start();
      send_byte(a, ack);
      chk(match ? "R2 address ack" : "R3 address no ack", int'(ack), int'(match));
      if (match && !a[0]) begin
        send_byte(a ^ 8'h9C, ack);
        chk("R4 ctrl ack", int'(ack), 1);
        exp_ctrl = a ^ 8'h9C;
      end else if (match) begin
        recv_byte(1'b0, d);
        chk("R6 first byte", int'(d), int'(buf_val(0)));
      end else begin
        send_byte(8'h20, ack);
        chk("R3 ignored byte", int'(ack), 0);
      end
      bus_stop();
      chk_mode("R5 sweep", exp_ctrl);
    end

    // R2 cross: wrong pair for the select level
    addr_sel = 1'b1;
    bus_start(); send_byte(8'h20, ack); bus_stop();
    chk("R2 0x20 with select high", int'(ack), 0);
    addr_sel = 1'b0;
    bus_start(); send_byte(8'h22, ack); bus_stop();
    chk("R2 0x22 with select low", int'(ack), 0);

    // R5 one field at a time
    for (int f = 0; f < 8; f++) begin
      bus_start(); send_byte(8'h20, ack); send_byte(8'(1 << f), ack); bus_stop();
      chk_mode("R5 single bit", 8'(1 << f));
    end

    // R4 second byte refused
    bus_start(); send_byte(8'h20, ack); send_byte(8'h5A, ack);
    send_byte(8'hC3, ack);
    chk("R4 second byte no ack", int'(ack), 0);
    bus_stop();
    chk_mode("R4 second byte ignored", 8'h5A);

    // R3 mismatch then a matching-looking byte without START
    bus_start(); send_byte(8'h24, ack); send_byte(8'h20, ack);
    chk("R3 no ack until start", int'(ack), 0);
    send_byte(8'h11, ack); bus_stop();
    chk_mode("R3 ctrl unchanged", 8'h5A);

    // R6/R7/R8 long read with wrap
    n0 = nack_cnt;
    bus_start(); send_byte(8'h21, ack);
    chk("R10 busy after match", int'(busy), 1);
    for (int k = 0; k < 17; k++) begin
      recv_byte(k != 16, d);
      chk(k < 16 ? "R6 read byte" : "R7 wrap byte", int'(d), int'(buf_val(k)));
      if (k == 3) chk("R7 index after acks", int'(rd_idx), 4);
    end
    wq(2);
    chk("R8 busy after nack", int'(busy), 0);
    chk("R8 single nack pulse", nack_cnt - n0, 1);
    send_byte(8'hFF, ack);
    chk("R8 silent after nack", int'(ack), 0);
    bus_stop();

    // R9 repeated start after a nack, R10 busy via start
    n0 = nack_cnt;
    bus_start(); send_byte(8'h21, ack);
    recv_byte(1'b1, d); recv_byte(1'b1, d);
    recv_byte(1'b0, d);
    chk("R6 third byte", int'(d), int'(buf_val(2)));
    bus_start();
    chk("R9 index after repeated start", int'(rd_idx), 0);
    chk("R8 nack count before restart", nack_cnt - n0, 1);
    send_byte(8'h21, ack);
    recv_byte(1'b0, d);
    chk("R9 restart reads byte 0", int'(d), int'(buf_val(0)));
    bus_stop();
    chk("R10 busy after stop", int'(busy), 0);

    bus_start(); send_byte(8'h20, ack); send_byte(8'h07, ack);
    chk("R10 busy held after write", int'(busy), 1);
    bus_start();
    chk("R10 busy cleared by start", int'(busy), 0);
    bus_stop();
    chk_mode("R4 write before restart", 8'h07);

    finish_run();
  end

endmodule